// File: doc/BRIEF.md
# Load and Store Byte-Lane Aligner

This block sits in the memory stage of a 32-bit pipeline, between a data memory that is accessed a word at a time and the register file. On a load it takes the full word read from memory, picks out the addressed byte or halfword, and sign- or zero-extends it to a register-width result. On a store it copies the low byte or halfword of the register data into every lane of the write word and raises only the byte enables of the addressed lanes. A word access passes through unchanged. The address adder is upstream, so the block sees only the two low address bits.

Memory is big-endian. Byte offset 0 is the most significant lane, bits 31:24, and halfword offset 0 is bits 31:16. Enable bit `i` covers bits `8i+7:8i`, so byte offset 0 drives enable bit 3. A halfword access at an odd address, or a word access at any address that is not a multiple of four, raises a misalignment flag and stops the write. All outputs are registered and appear one clock after their inputs.

Top module: `ldst_aligner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all outputs are zero.
- R2: Each output reflects the inputs sampled at the previous rising clock edge. Between edges the outputs do not change.
- R3: Read codes 3 (signed) and 7 (unsigned) load one byte. Offset `k` takes bits `31-8k : 24-8k`. Code 3 extends bit 7 of that byte and code 7 zero-fills bits 31:8.
- R4: Read codes 2 (signed) and 6 (unsigned) load a halfword. It is bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1. Address bit 0 plays no part in the result.
- R5: Read code 1 returns the whole memory word, whatever the address bits.
- R6: Read codes 0, 4 and 5 are not loads: `ld_result` is zero.
- R7: Write code 1 (word) sets `wr_data` to the store data and `byte_en` to 4'b1111.
- R8: Write code 2 (halfword) copies store bits 15:0 into both halves of `wr_data`. `byte_en` is 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1.
- R9: Write code 3 (byte) copies store bits 7:0 into all four lanes. `byte_en` is the single bit 4'b1000 shifted right by the offset.
- R10: `misalign` is 1 exactly when the read or the write is misaligned: a halfword with address bit 0 set, or a word with either low bit set. When it is 1, `byte_en` is zero.
- R11: Write code 0 gives a zero `byte_en` and a zero `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_code | input | 3 | Load kind: bit 2 selects zero-extension, bits 1:0 select the size (0 none, 1 word, 2 halfword, 3 byte) |
| wr_code | input | 2 | Store kind: 0 none, 1 word, 2 halfword, 3 byte |
| addr_lo | input | 2 | Low two bits of the effective address |
| mem_rdata | input | 32 | Word read from data memory |
| st_data | input | 32 | Register value to be stored |
| ld_result | output | 32 | Extended load value for the register file |
| wr_data | output | 32 | Write word with the lanes replicated |
| byte_en | output | 4 | Per-lane write enables, bit i covers bits 8i+7:8i |
| misalign | output | 1 | Misaligned-access flag |

## Verification
The hardest case to reach is a load and a store issued in the same cycle where only one of them is misaligned. A misaligned word load paired with an aligned byte store must still clear every write enable. The bench forces this pairing directly and also runs several hundred cycles with random read codes, write codes and offsets. Every lane of the memory word is loaded with a different value, some with the top bit set and some clear, so a wrong lane or a wrong extension shows up as a wrong value.

// File: rtl/ldst_align_pkg.sv
package ldst_align_pkg;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_HALF = 2'd2,
        SZ_BYTE = 2'd3
    } acc_size_e;

    typedef struct packed {
        acc_size_e size;
        logic      zext;
    } rd_req_t;

    // Bit 2 is the zero-extend flag over a size field; unsigned word and code 4 are not loads.
    function automatic rd_req_t decode_rd(input logic [2:0] code);
        rd_req_t r;
        r.size = acc_size_e'(code[1:0]);
        r.zext = code[2];
        if (code == 3'd4 || code == 3'd5) begin
            r.size = SZ_NONE;
            r.zext = 1'b0;
        end
        return r;
    endfunction

    function automatic acc_size_e decode_wr(input logic [1:0] code);
        return acc_size_e'(code);
    endfunction

    // Misalignment from the two lowest address bits.
    function automatic logic is_misaligned(input acc_size_e sz, input logic [1:0] lo);
        case (sz)
            SZ_HALF: return lo[0];
            SZ_WORD: return |lo;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lda_load_sel.sv
module lda_load_sel
    import ldst_align_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  rd_req_t                        req,
    input  logic [$clog2(DATA_W/8)-1:0]    addr,
    input  logic [DATA_W-1:0]              rdata,
    output logic [DATA_W-1:0]              result
);
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned HALVES = LANES / 2;
    localparam int unsigned AW     = $clog2(LANES);

    logic [7:0]  lane [LANES];
    logic [15:0] half [HALVES];

    // Big-endian: offset 0 is the most significant lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = rdata[DATA_W-1-8*g -: 8];
    end
    for (genvar g = 0; g < HALVES; g++) begin : g_half
        assign half[g] = rdata[DATA_W-1-16*g -: 16];
    end

    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b  = lane[addr];
        sel_h  = half[addr[AW-1:1]];
        result = '0;
        case (req.size)
            SZ_BYTE: result = req.zext ? {{(DATA_W-8){1'b0}}, sel_b}
                                       : {{(DATA_W-8){sel_b[7]}}, sel_b};
            SZ_HALF: result = req.zext ? {{(DATA_W-16){1'b0}}, sel_h}
                                       : {{(DATA_W-16){sel_h[15]}}, sel_h};
            SZ_WORD: result = rdata;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/lda_store_rep.sv
module lda_store_rep
    import ldst_align_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  acc_size_e                      size,
    input  logic [$clog2(DATA_W/8)-1:0]    addr,
    input  logic [DATA_W-1:0]              sdata,
    input  logic                           suppress,
    output logic [DATA_W-1:0]              wdata,
    output logic [DATA_W/8-1:0]            be
);
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned HALVES = LANES / 2;
    localparam int unsigned AW     = $clog2(LANES);

    always_comb begin
        case (size)
            SZ_BYTE: wdata = {LANES{sdata[7:0]}};
            SZ_HALF: wdata = {HALVES{sdata[15:0]}};
            SZ_WORD: wdata = sdata;
            default: wdata = '0;
        endcase
    end

    // Enable bit g covers bits 8g+7:8g, which is big-endian offset LANES-1-g.
    for (genvar g = 0; g < LANES; g++) begin : g_be
        localparam int unsigned OFF = LANES - 1 - g;
        logic hit;
        always_comb begin
            case (size)
                SZ_BYTE: hit = (addr == AW'(OFF));
                SZ_HALF: hit = (addr[AW-1:1] == (AW-1)'(OFF / 2));
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end
        assign be[g] = hit & ~suppress;
    end
endmodule

// File: rtl/ldst_aligner.sv
module ldst_aligner
    import ldst_align_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           rd_code,
    input  logic [1:0]           wr_code,
    input  logic [1:0]           addr_lo,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic [DATA_W-1:0]    st_data,
    output logic [DATA_W-1:0]    ld_result,
    output logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W/8-1:0]  byte_en,
    output logic                 misalign
);
    localparam int unsigned LANES = DATA_W / 8;

    rd_req_t               rreq;
    acc_size_e             wsize;
    logic                  mis_c;
    logic [DATA_W-1:0]     ld_c;
    logic [DATA_W-1:0]     wd_c;
    logic [LANES-1:0]      be_c;

    always_comb begin
        rreq  = decode_rd(rd_code);
        wsize = decode_wr(wr_code);
        mis_c = is_misaligned(rreq.size, addr_lo) | is_misaligned(wsize, addr_lo);
    end

    lda_load_sel #(.DATA_W(DATA_W)) u_load (
        .req    (rreq),
        .addr   (addr_lo),
        .rdata  (mem_rdata),
        .result (ld_c)
    );

    lda_store_rep #(.DATA_W(DATA_W)) u_store (
        .size     (wsize),
        .addr     (addr_lo),
        .sdata    (st_data),
        .suppress (mis_c),
        .wdata    (wd_c),
        .be       (be_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_result <= '0;
            wr_data   <= '0;
            byte_en   <= '0;
            misalign  <= 1'b0;
        end else begin
            ld_result <= ld_c;
            wr_data   <= wd_c;
            byte_en   <= be_c;
            misalign  <= mis_c;
        end
    end
endmodule

// File: rtl/ldst_aligner_chk.sv
module ldst_aligner_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic [2:0]           rd_code,
    input logic [1:0]           wr_code,
    input logic [1:0]           addr_lo,
    input logic [DATA_W-1:0]    mem_rdata,
    input logic [DATA_W-1:0]    st_data,
    input logic [DATA_W-1:0]    ld_result,
    input logic [DATA_W-1:0]    wr_data,
    input logic [DATA_W/8-1:0]  byte_en,
    input logic                 misalign
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_idle_store_R11: assert property (@(posedge clk) disable iff (rst)
        armed && $past(wr_code) == 2'd0 |-> byte_en == '0 && wr_data == '0);

    assert_byte_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        armed && $past(wr_code) == 2'd3 && !misalign |-> $countones(byte_en) == 1);

    assert_half_pair_R8: assert property (@(posedge clk) disable iff (rst)
        armed && $past(wr_code) == 2'd2 && !misalign |-> $countones(byte_en) == 2);

    assert_mis_blocks_write_R10: assert property (@(posedge clk) disable iff (rst)
        misalign |-> byte_en == '0);

    assert_zext_byte_R3: assert property (@(posedge clk) disable iff (rst)
        armed && $past(rd_code) == 3'd7 |-> ld_result[DATA_W-1:8] == '0);

    assert_no_load_R6: assert property (@(posedge clk) disable iff (rst)
        armed && ($past(rd_code) == 3'd0 || $past(rd_code) == 3'd4 || $past(rd_code) == 3'd5)
        |-> ld_result == '0);

    assert_word_pass_R5: assert property (@(posedge clk) disable iff (rst)
        armed && $past(rd_code) == 3'd1 |-> ld_result == $past(mem_rdata));
endmodule

bind ldst_aligner ldst_aligner_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ldst_aligner_bench.sv
`timescale 1ns/1ps
module ldst_aligner_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  rd_code;
    logic [1:0]  wr_code;
    logic [1:0]  addr_lo;
    logic [31:0] mem_rdata, st_data;
    logic [31:0] ld_result, wr_data;
    logic [3:0]  byte_en;
    logic        misalign;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ldst_aligner u_ldst_aligner (.*);

    logic [31:0] e_ld = '0, e_wd = '0;
    logic [3:0]  e_be = '0;
    logic        e_mis = 1'b0;
    string       t_ld = "R1", t_wr = "R1", t_be = "R1";

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string pre);
        chk({pre, t_ld}, "ld_result", ld_result, e_ld);
        chk({pre, t_wr}, "wr_data",   wr_data,   e_wd);
        chk({pre, t_be}, "byte_en",   {28'd0, byte_en}, {28'd0, e_be});
        chk({pre, "R10"}, "misalign", {31'd0, misalign}, {31'd0, e_mis});
    endtask

    // Behavioural model built from the requirement text.
    task automatic model(input int rc, input int wc, input int a, input logic [31:0] rd, input logic [31:0] sd);
        logic [15:0] hw;
        logic [7:0]  b;
        e_mis = ((rc == 2 || rc == 6) && (a % 2 == 1)) || (rc == 1 && a != 0) ||
                (wc == 2 && (a % 2 == 1)) || (wc == 1 && a != 0);
        hw = (a / 2 == 0) ? rd[31:16] : rd[15:0];
        b  = 8'((rd >> (24 - 8 * a)) & 32'hFF);
        case (rc)
            1: begin e_ld = rd; t_ld = "R5"; end
            2: begin e_ld = {{16{hw[15]}}, hw}; t_ld = "R4"; end
            6: begin e_ld = {16'd0, hw}; t_ld = "R4"; end
            3: begin e_ld = {{24{b[7]}}, b}; t_ld = "R3"; end
            7: begin e_ld = {24'd0, b}; t_ld = "R3"; end
            default: begin e_ld = '0; t_ld = "R6"; end
        endcase
        case (wc)
            1: begin e_wd = sd; e_be = 4'hF; t_wr = "R7"; end
            2: begin e_wd = {sd[15:0], sd[15:0]}; e_be = (a / 2 == 0) ? 4'b1100 : 4'b0011; t_wr = "R8"; end
            3: begin e_wd = {4{sd[7:0]}}; e_be = 4'b1000 >> a; t_wr = "R9"; end
            default: begin e_wd = '0; e_be = '0; t_wr = "R11"; end
        endcase
        t_be = t_wr;
        if (e_mis) begin e_be = '0; t_be = "R10"; end
    endtask

    // Called at a falling edge: drive, confirm outputs hold (R2), then check after the next edge.
    task automatic step(input int rc, input int wc, input int a, input logic [31:0] rd, input logic [31:0] sd);
        rd_code = 3'(rc); wr_code = 2'(wc); addr_lo = 2'(a); mem_rdata = rd; st_data = sd;
        #1;
        check_all("R2/");
        model(rc, wc, a, rd, sd);
        @(negedge clk);
        check_all("");
    endtask

    initial begin
        rst = 1'b1; rd_code = '0; wr_code = '0; addr_lo = '0; mem_rdata = '0; st_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1/");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1/");
        for (int rc = 0; rc < 8; rc++)
            for (int a = 0; a < 4; a++) begin
                step(rc, 0, a, 32'h807F01FE, 32'h0);
                step(rc, 0, a, 32'h7E81C33C, 32'h0);
            end
        for (int wc = 0; wc < 4; wc++)
            for (int a = 0; a < 4; a++)
                step(0, wc, a, 32'h0, 32'hA5C39E17);
        // R10: misaligned word load blocks an otherwise aligned byte store
        step(1, 3, 2, 32'h11223344, 32'h000000EE);
        step(2, 3, 1, 32'h8899AABB, 32'h00000077);
        step(3, 1, 1, 32'hF0E0D0C0, 32'h12345678);
        for (int i = 0; i < 400; i++)
            step(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                 $urandom, $urandom);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule